// File: doc/BRIEF.md
# Microcoded ALU Execution Slice

This block is the execution slice that sits under a horizontal microinstruction. Seven raw control bits and a carry-in arrive straight from the control store, with no opcode decoder in between. The bits are split into three separate fields. A two-bit routing field picks which source values feed the two ALU inputs. A three-bit function field picks one of eight arithmetic or logic operations. A two-bit post-shift field chooses what is written into the result register: the ALU value unchanged, halved, doubled, or nothing at all, so the register keeps its contents.

The result register `z_out` is loaded on the rising clock edge. The carry and signed-overflow signals come straight from the current inputs, with no register, and are taken before the shift stage. A separate flag unit can latch them in the same cycle. The datapath width is the parameter `W`, with a default of 8.

Top module: `uexec_slice`

## Requirements
- R1: `route_sel` sets the ALU inputs A and B as follows: 00 gives A=X and B=Y, 01 gives A=X and B=0, 10 gives A=Y and B=0, 11 gives A=Y and B=X.
- R2: `func_sel` 000 computes A+B+carry_in modulo 2^W. `carry_out` is the carry out of the top bit.
- R3: `func_sel` 001 computes A-B-(1-carry_in) modulo 2^W. `carry_out` is 1 exactly when that difference, taken as unsigned, is not negative (it is the inverted borrow).
- R4: `func_sel` 010 computes B-A-(1-carry_in) modulo 2^W. `carry_out` is the inverted borrow, as in R3.
- R5: The logic codes are: `func_sel` 011 gives A|B, 100 gives A&B, 101 gives ~A&B, 110 gives A^B and 111 gives ~(A^B). For all five codes `carry_out` and `ovf_out` are 0.
- R6: For codes 000, 001 and 010, `ovf_out` is 1 exactly when the signed two's-complement result of the operation, taken as an unbounded integer, lies outside the range -2^(W-1) to 2^(W-1)-1.
- R7: With `shift_sel` 00, the next `z_out` is the ALU value.
- R8: With `shift_sel` 01, the next `z_out` is the ALU value shifted right by one, with 0 entering the top bit.
- R9: With `shift_sel` 10, the next `z_out` is the ALU value shifted left by one, with 0 entering bit 0.
- R10: With `shift_sel` 11, `z_out` keeps its value whatever the other inputs do.
- R11: While `rst` is high at a rising edge, `z_out` becomes 0. Reset takes priority over every shift code.
- R12: `carry_out` and `ovf_out` follow the present inputs within the same cycle, without waiting for a clock edge, and they do not depend on `shift_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | W | Source value X |
| y_in | input | W | Source value Y |
| route_sel | input | 2 | Operand routing field (bit 1 is the first control bit) |
| func_sel | input | 3 | Function field |
| shift_sel | input | 2 | Post-shift / write field |
| carry_in | input | 1 | Carry-in to the arithmetic codes |
| z_out | output | W | Result register |
| carry_out | output | 1 | Raw carry / inverted borrow |
| ovf_out | output | 1 | Raw signed overflow |

## Verification
The only state in the slice is the result register. A wrong value caught there shows on `z_out` one edge after the vector that loaded it. With the hold code it then stays wrong until the next write, so the bench checks after every edge and also while holding with inputs that are moving. A wrong routing or function decode shows up without any clock as a bad `carry_out` or `ovf_out`, because those come straight from the inputs. The bench therefore samples them before each edge, and it samples `z_out` one edge later.

// File: rtl/uexec_pkg.sv
package uexec_pkg;

  typedef enum logic [1:0] {
    RT_XY = 2'b00,
    RT_X0 = 2'b01,
    RT_Y0 = 2'b10,
    RT_YX = 2'b11
  } route_e;

  typedef enum logic [2:0] {
    FN_ADD  = 3'b000,
    FN_SUB  = 3'b001,
    FN_RSUB = 3'b010,
    FN_OR   = 3'b011,
    FN_AND  = 3'b100,
    FN_ANDN = 3'b101,
    FN_XOR  = 3'b110,
    FN_XNOR = 3'b111
  } func_e;

  typedef enum logic [1:0] {
    SH_PASS   = 2'b00,
    SH_HALF   = 2'b01,
    SH_DOUBLE = 2'b10,
    SH_HOLD   = 2'b11
  } shift_e;

  function automatic logic is_arith(input func_e f);
    return (f == FN_ADD) || (f == FN_SUB) || (f == FN_RSUB);
  endfunction

  // one-bit logic unit, shared by every bit slice
  function automatic logic bit_logic(input func_e f, input logic a, input logic b);
    case (f)
      FN_OR:   return a | b;
      FN_AND:  return a & b;
      FN_ANDN: return ~a & b;
      FN_XOR:  return a ^ b;
      FN_XNOR: return ~(a ^ b);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uexec_opsel.sv
module uexec_opsel
  import uexec_pkg::*;
#(
  parameter int W = 8
) (
  input  route_e         route,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  output logic [W-1:0]   opa,
  output logic [W-1:0]   opb
);

  localparam logic [W-1:0] ZERO = '0;

  always_comb begin
    unique case (route)
      RT_XY:   begin opa = x_i; opb = y_i;  end
      RT_X0:   begin opa = x_i; opb = ZERO; end
      RT_Y0:   begin opa = y_i; opb = ZERO; end
      default: begin opa = y_i; opb = x_i;  end
    endcase
  end

endmodule

// File: rtl/uexec_alu.sv
module uexec_alu
  import uexec_pkg::*;
#(
  parameter int W = 8
) (
  input  func_e          func,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           carry,
  output logic           ovf
);

  localparam int MSB = W - 1;

  function automatic logic [W:0] add_w(input logic [W-1:0] p, input logic [W-1:0] q,
                                       input logic ci);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, ci};
  endfunction

  // both addends share a sign but the sum does not
  function automatic logic ovf_w(input logic pm, input logic qm, input logic rm);
    return (pm == qm) && (rm != pm);
  endfunction

  logic [W-1:0] add_l;
  logic [W-1:0] add_r;
  logic [W:0]   sum_full;
  logic         arith_sel;
  logic         arith_ovf;
  logic [W-1:0] logic_res;

  // a single adder: subtract is addition of the complement plus carry-in
  always_comb begin
    add_l = (func == FN_RSUB) ? opb : opa;
    case (func)
      FN_SUB:  add_r = ~opb;
      FN_RSUB: add_r = ~opa;
      default: add_r = opb;
    endcase
  end

  assign sum_full  = add_w(add_l, add_r, cin);
  assign arith_ovf = ovf_w(add_l[MSB], add_r[MSB], sum_full[MSB]);
  assign arith_sel = is_arith(func);

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign logic_res[k] = bit_logic(func, opa[k], opb[k]);
  end

  assign res   = arith_sel ? sum_full[W-1:0] : logic_res;
  assign carry = arith_sel & sum_full[W];
  assign ovf   = arith_sel & arith_ovf;

endmodule

// File: rtl/uexec_shift.sv
module uexec_shift
  import uexec_pkg::*;
#(
  parameter int W = 8
) (
  input  shift_e         mode,
  input  logic [W-1:0]   alu_res,
  input  logic [W-1:0]   z_q,
  output logic [W-1:0]   z_d
);

  always_comb begin
    unique case (mode)
      SH_PASS:   z_d = alu_res;
      SH_HALF:   z_d = {1'b0, alu_res[W-1:1]};
      SH_DOUBLE: z_d = {alu_res[W-2:0], 1'b0};
      default:   z_d = z_q;
    endcase
  end

endmodule

// File: rtl/uexec_slice.sv
module uexec_slice
  import uexec_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   x_in,
  input  logic [W-1:0]   y_in,
  input  logic [1:0]     route_sel,
  input  logic [2:0]     func_sel,
  input  logic [1:0]     shift_sel,
  input  logic           carry_in,
  output logic [W-1:0]   z_out,
  output logic           carry_out,
  output logic           ovf_out
);

  route_e       route_w;
  func_e        func_w;
  shift_e       shift_w;
  logic [W-1:0] opa_w;
  logic [W-1:0] opb_w;
  logic [W-1:0] alu_res;
  logic [W-1:0] z_next;
  logic [W-1:0] z_q;

  assign route_w = route_e'(route_sel);
  assign func_w  = func_e'(func_sel);
  assign shift_w = shift_e'(shift_sel);

  uexec_opsel #(.W(W)) u_opsel (
    .route (route_w),
    .x_i   (x_in),
    .y_i   (y_in),
    .opa   (opa_w),
    .opb   (opb_w)
  );

  uexec_alu #(.W(W)) u_alu (
    .func  (func_w),
    .opa   (opa_w),
    .opb   (opb_w),
    .cin   (carry_in),
    .res   (alu_res),
    .carry (carry_out),
    .ovf   (ovf_out)
  );

  uexec_shift #(.W(W)) u_shift (
    .mode    (shift_w),
    .alu_res (alu_res),
    .z_q     (z_q),
    .z_d     (z_next)
  );

  always_ff @(posedge clk) begin
    if (rst) z_q <= '0;
    else     z_q <= z_next;
  end

  assign z_out = z_q;

  // R11
  reset_clear_chk: assert property (@(posedge clk) rst |=> z_out == '0);

  // R10
  hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    shift_sel == 2'b11 |=> $stable(z_out));

  // R7
  pass_load_chk: assert property (@(posedge clk) disable iff (rst)
    shift_sel == 2'b00 |=> z_out == $past(alu_res));

  // R8
  half_msb_chk: assert property (@(posedge clk) disable iff (rst)
    shift_sel == 2'b01 |=> !z_out[W-1]);

  // R9
  double_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    shift_sel == 2'b10 |=> !z_out[0]);

  // R5
  logic_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    func_sel >= 3'd3 |-> !carry_out && !ovf_out);

  // R1
  zero_route_chk: assert property (@(posedge clk) disable iff (rst)
    (route_sel == 2'b01 || route_sel == 2'b10) && func_sel == 3'b100 |-> alu_res == '0);

endmodule

// File: tb/sim_uexec_slice.sv
module sim_uexec_slice;

  localparam int W  = 8;
  localparam int MX = (1 << W) - 1;
  localparam int HI = (1 << (W - 1)) - 1;
  localparam int LO = -(1 << (W - 1));

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] x_in = '0;
  logic [W-1:0] y_in = '0;
  logic [1:0]   route_sel = '0;
  logic [2:0]   func_sel = '0;
  logic [1:0]   shift_sel = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] z_out;
  logic         carry_out;
  logic         ovf_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] exp_z = '0;

  always #5 clk = ~clk;

  uexec_slice #(.W(W)) u0 (
    .clk, .rst, .x_in, .y_in, .route_sel, .func_sel, .shift_sel,
    .carry_in, .z_out, .carry_out, .ovf_out
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pick(input int i);
    case (i)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h7F;
      4: return 8'h80;  5: return 8'h81;  6: return 8'hFE;  7: return 8'hFF;
      8: return 8'h55;  9: return 8'hAA; 10: return 8'h0F; 11: return 8'hF0;
      12: return 8'h3C; 13: return 8'h40; 14: return 8'hC3; default: return 8'h99;
    endcase
  endfunction

  function automatic int sx(input int v);
    return (v > HI) ? v - (MX + 1) : v;
  endfunction

  function automatic string ftag(input int f);
    case (f)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic string stag(input int s);
    case (s)
      0: return "R7";
      1: return "R8";
      2: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input int r, input int f, input int s, input int c,
                       input int xv, input int yv);
    int a, b, res, cy, sres, ov;
    route_sel = 2'(r); func_sel = 3'(f); shift_sel = 2'(s);
    carry_in = 1'(c); x_in = W'(xv); y_in = W'(yv);
    // R1 operand routing
    case (r)
      0: begin a = xv; b = yv; end
      1: begin a = xv; b = 0;  end
      2: begin a = yv; b = 0;  end
      default: begin a = yv; b = xv; end
    endcase
    cy = 0; ov = 0; sres = 0;
    case (f)
      0: begin res = a + b + c; cy = (res > MX) ? 1 : 0; sres = sx(a) + sx(b) + c; end
      1: begin res = a - b - (1 - c); cy = (res >= 0) ? 1 : 0; sres = sx(a) - sx(b) - (1 - c); end
      2: begin res = b - a - (1 - c); cy = (res >= 0) ? 1 : 0; sres = sx(b) - sx(a) - (1 - c); end
      3: res = a | b;
      4: res = a & b;
      5: res = (MX - a) & b;
      6: res = a ^ b;
      default: res = MX - (a ^ b);
    endcase
    res = res & MX;
    if (f < 3) ov = (sres > HI || sres < LO) ? 1 : 0;
    #1;
    check({ftag(f), " R12 carry"}, int'(carry_out), cy);
    check({"R6 R12 ovf ", ftag(f)}, int'(ovf_out), ov);
    case (s)
      0: exp_z = W'(res);
      1: exp_z = W'(res >> 1);
      2: exp_z = W'((res << 1) & MX);
      default: ;
    endcase
    @(posedge clk); #1;
    check({"R1 ", ftag(f), " ", stag(s)}, int'(z_out), int'(exp_z));
  endtask

  initial begin
    #120_0000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    x_in = 8'hFF; y_in = 8'hFF; shift_sel = 2'b00;
    @(posedge clk); #1;
    check("R11 reset state", int'(z_out), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    exp_z = '0;
    for (int r = 0; r < 4; r++)
      for (int f = 0; f < 8; f++)
        for (int s = 0; s < 4; s++)
          for (int c = 0; c < 2; c++)
            for (int i = 0; i < 16; i++)
              for (int j = 0; j < 16; j++)
                apply(r, f, s, c, pick(i), pick(j));
    // R11 reset wins over a load and over hold
    apply(0, 3, 0, 0, 8'h5A, 8'h00);
    rst = 1'b1; shift_sel = 2'b00; x_in = 8'hFF;
    @(posedge clk); #1;
    check("R11 reset over load", int'(z_out), 0);
    shift_sel = 2'b11;
    @(posedge clk); #1;
    check("R11 reset over hold", int'(z_out), 0);
    rst = 1'b0;
    exp_z = '0;
    apply(3, 0, 3, 1, 8'h12, 8'h34);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule